// File: doc/BRIEF.md
# Posted Store Write Buffer

This block sits between a CPU core and a slower system bus and absorbs stores so the core does not wait for each bus write. The core pushes tagged entries into a sixteen-slot queue over a valid/ready stream. An entry is one of two kinds. An address entry only sets the buffer's running target address. A data entry carries a byte, halfword or word value and whether it continues a sequential burst. Each data entry becomes exactly one bus write, and after every write the running address steps forward by the transfer size.

The buffer drains one entry at a time through a request/acknowledge bus master port. A non-sequential transfer is held back until the slow bus clock reaches an edge. A sequential word follows on at once. A write into the main-RAM region, which the environment flags from the bus address, keeps the bus occupied for two bus cycles. Back-pressure: `push_ready` falls while the queue holds sixteen entries or while a flush is requested, and an entry is taken only in a cycle where both `push_valid` and `push_ready` are high. Raising `drain_req` flushes everything. `drain_done` rises once nothing is pending.

Top module: `wbuf_store_buffer`

## Requirements
- R1: Out of reset the buffer is empty. `bus_req` is low, `push_ready` is high, and `drain_done` is low while `drain_req` is low.
- R2: Tag encoding: 0 is a non-sequential byte (`bus_size`=0), 1 is a non-sequential halfword (`bus_size`=1), 2 is a non-sequential word (`bus_size`=2), and 3 is a sequential word (`bus_size`=2, `bus_seq`=1). `bus_seq` is 0 for tags 0 to 2.
- R3: A tag of 4 or above is an address entry. It makes no bus request and loads its value into `bus_addr` (the running address).
- R4: When a data write is acknowledged, the running address advances by 1, 2 or 4 for sizes 0, 1 and 2.
- R5: Entries are written in push order. `bus_req` stays high with `bus_addr`, `bus_wdata` and `bus_size` unchanged until `bus_ack` is seen. A cycle with `bus_req` and `bus_ack` both high retires the head entry.
- R6: The queue holds 16 entries. `push_ready` is low while 16 are pending, and it recovers after an acknowledge.
- R7: A data entry pushed into an empty buffer in cycle t raises `bus_req` no earlier than cycle t+2.
- R8: Cycles are counted from 0 after reset. A non-sequential request rises only in a cycle whose count is a multiple of RATIO = 2^RATIO_LOG2. A sequential request is not realigned.
- R9: After an acknowledge in cycle k with `bus_is_main` high, the next `bus_req` rises no earlier than cycle k + MAIN_BUS_CYC*RATIO + 1.
- R10: While `drain_req` is high, `push_ready` is low. `drain_done` is high exactly when `drain_req` is high, no entry is pending and `bus_req` is low.
- R11: `bus_req` is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Core offers an entry |
| push_ready | output | 1 | Buffer accepts the offered entry this cycle |
| push_tag | input | 3 | Entry kind (see R2, R3) |
| push_val | input | 32 | Data value or new address |
| drain_req | input | 1 | Flush request; holds the core off |
| drain_done | output | 1 | Flush complete |
| bus_req | output | 1 | Bus write request |
| bus_addr | output | 32 | Running write address |
| bus_wdata | output | 32 | Write data |
| bus_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_seq | output | 1 | Sequential transfer |
| bus_ack | input | 1 | Bus accepts the current write |
| bus_is_main | input | 1 | Current address lies in main RAM |

## Verification
The bench fills the queue while acknowledges are withheld. This shows that the sixteenth entry closes `push_ready`, and a design with an off-by-one in its full test would either drop an entry or stall one entry early. It sends non-sequential writes at varying phases to catch a request that rises off a slow-bus edge. It mixes main-RAM and other regions so that a missing or short occupancy hold shows up as an early request. Address entries placed between data, sequential runs after non-sequential ones, and flushes with pushes held during them expose a wrong address step, an address entry turned into a bus write, or `drain_done` raised while a write is still outstanding.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WB_DATA_W = 32;
  localparam int WB_TAG_W  = 3;

  typedef enum logic [WB_TAG_W-1:0] {
    TAG_NS_BYTE  = 3'd0,
    TAG_NS_HALF  = 3'd1,
    TAG_NS_WORD  = 3'd2,
    TAG_SEQ_WORD = 3'd3,
    TAG_ADDR     = 3'd4
  } wb_tag_e;

  function automatic logic tag_is_addr(input logic [WB_TAG_W-1:0] t);
    return t[2];
  endfunction

  function automatic logic tag_is_seq(input logic [WB_TAG_W-1:0] t);
    return t == TAG_SEQ_WORD;
  endfunction

  function automatic logic [1:0] tag_size(input logic [WB_TAG_W-1:0] t);
    case (t)
      TAG_NS_BYTE: return 2'd0;
      TAG_NS_HALF: return 2'd1;
      default:     return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             empty_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      empty_q <= 1'b1;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)
        empty_q <= 1'b0;
      else if (pop && !push && (bump(rd_q) == wr_q))
        empty_q <= 1'b1;
    end
  end

  assign empty = empty_q;
  assign full  = (wr_q == rd_q) && !empty_q;
  assign head  = mem[rd_q];

  // R6: nothing is written into a full queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: a retire never happens on an empty queue
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wbuf_pacer.sv
module wbuf_pacer #(
  parameter int RATIO_LOG2   = 1,
  parameter int MAIN_BUS_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_done,
  output logic edge_next,
  output logic bus_free
);
  localparam int RATIO  = 1 << RATIO_LOG2;
  localparam int HOLD   = MAIN_BUS_CYC * RATIO;
  localparam int BUSY_W = $clog2(HOLD + 1);
  localparam logic [BUSY_W-1:0] RELOAD = BUSY_W'(HOLD - 1);

  logic [BUSY_W-1:0] busy_q;

  generate
    if (RATIO_LOG2 == 0) begin : g_same_clk
      assign edge_next = 1'b1;
    end else begin : g_div_clk
      logic [RATIO_LOG2-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
      end
      // next cycle lands on a slow-bus edge when the phase wraps
      assign edge_next = &phase_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_q <= '0;
    else if (main_done)      busy_q <= RELOAD;
    else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
  end

  assign bus_free = (busy_q == '0);
endmodule

// File: rtl/wbuf_engine.sv
module wbuf_engine
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = WB_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                head_valid,
  input  logic [WB_TAG_W-1:0] head_tag,
  input  logic [DW-1:0]       head_val,
  input  logic                edge_next,
  input  logic                bus_free,
  input  logic                bus_ack,
  input  logic                bus_is_main,
  output logic                pop,
  output logic                main_done,
  output logic                bus_req,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  output logic [1:0]          bus_size,
  output logic                bus_seq
);
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic          load_addr, done, issue;
  logic [AW-1:0] step;

  always_comb begin
    load_addr = !req_q && head_valid && tag_is_addr(head_tag);
    done      = req_q && bus_ack;
    issue     = !req_q && head_valid && !tag_is_addr(head_tag) && bus_free &&
                (tag_is_seq(head_tag) || edge_next);
    step      = AW'(1) << tag_size(head_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      if (issue)     req_q <= 1'b1;
      else if (done) req_q <= 1'b0;
      if (load_addr) addr_q <= AW'(head_val);
      else if (done) addr_q <= addr_q + step;
    end
  end

  assign pop       = done || load_addr;
  assign main_done = done && bus_is_main;
  assign bus_req   = req_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = head_val;
  assign bus_size  = tag_size(head_tag);
  assign bus_seq   = tag_is_seq(head_tag);

  // R5: an outstanding write holds its fields until acknowledged
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) &&
                            $stable(bus_wdata) && $stable(bus_size));
  // R11: request drops right after the acknowledge
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);
endmodule

// File: rtl/wbuf_store_buffer.sv
module wbuf_store_buffer
  import wbuf_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int RATIO_LOG2   = 1,
  parameter int MAIN_BUS_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_valid,
  output logic                 push_ready,
  input  logic [WB_TAG_W-1:0]  push_tag,
  input  logic [WB_DATA_W-1:0] push_val,
  input  logic                 drain_req,
  output logic                 drain_done,
  output logic                 bus_req,
  output logic [31:0]          bus_addr,
  output logic [WB_DATA_W-1:0] bus_wdata,
  output logic [1:0]           bus_size,
  output logic                 bus_seq,
  input  logic                 bus_ack,
  input  logic                 bus_is_main
);
  localparam int ENT_W = WB_TAG_W + WB_DATA_W;

  logic             q_empty, q_full, q_push, q_pop;
  logic [ENT_W-1:0] q_head;
  logic             edge_next, bus_free, main_done;

  assign push_ready = !q_full && !drain_req;
  assign q_push     = push_valid && push_ready;
  assign drain_done = drain_req && q_empty && !bus_req;

  wbuf_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data({push_tag, push_val}),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  wbuf_pacer #(.RATIO_LOG2(RATIO_LOG2), .MAIN_BUS_CYC(MAIN_BUS_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n), .main_done(main_done),
    .edge_next(edge_next), .bus_free(bus_free)
  );

  wbuf_engine #(.AW(32), .DW(WB_DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .head_valid(!q_empty),
    .head_tag(q_head[ENT_W-1 -: WB_TAG_W]),
    .head_val(q_head[WB_DATA_W-1:0]),
    .edge_next(edge_next), .bus_free(bus_free),
    .bus_ack(bus_ack), .bus_is_main(bus_is_main),
    .pop(q_pop), .main_done(main_done),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_seq(bus_seq)
  );

  // R6: no acceptance while the queue is full
  p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push_ready);
  // R10: core held off during a flush
  p_drain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !push_ready);
  // R8: non-sequential requests start on a slow-bus edge
  p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && !bus_seq |-> $past(edge_next));
  // R9: no new request while main RAM is still occupied
  p_main_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(bus_free));
  // R3: an outstanding request always belongs to a data entry
  p_addr_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !q_head[ENT_W-1]);
endmodule

// File: tb/wbuf_store_buffer_tb.sv
module wbuf_store_buffer_tb;
  localparam int DEPTH = 16;
  localparam int RL2   = 1;
  localparam int RATIO = 1 << RL2;
  localparam int MBC   = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, push_valid, drain_req, bus_ack;
  logic [2:0]  push_tag;
  logic [31:0] push_val;
  logic        push_ready, drain_done, bus_req, bus_seq, bus_is_main;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;

  assign bus_is_main = (bus_addr[31:24] == 8'h02);

  wbuf_store_buffer #(.DEPTH(DEPTH), .RATIO_LOG2(RL2), .MAIN_BUS_CYC(MBC)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_tag(push_tag), .push_val(push_val), .drain_req(drain_req),
    .drain_done(drain_done), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_seq(bus_seq),
    .bus_ack(bus_ack), .bus_is_main(bus_is_main)
  );

  int checks = 0, fails = 0, wd = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int sz(input logic [2:0] t);
    return (t == 3'd0) ? 0 : (t == 3'd1) ? 1 : 2;
  endfunction

  // reference model state
  logic [34:0] mq[$];
  bit          m_req, last_acc, main_pend, push_pend, prev_req;
  logic [31:0] m_cur;
  int          m_busy, cyc, ack_cyc, main_ack_cyc, push_cyc;

  task automatic compare();
    logic [2:0] ht;
    bit rise;
    ht = (mq.size() > 0) ? mq[0][34:32] : 3'd0;
    chk(push_ready == (mq.size() < DEPTH && !drain_req), "R6", "push_ready",
        32'(push_ready), 32'(mq.size() < DEPTH && !drain_req));
    chk(bus_req == m_req, "R5", "bus_req", 32'(bus_req), 32'(m_req));
    chk(bus_addr == m_cur, "R4", "bus_addr (R3 loads)", bus_addr, m_cur);
    if (m_req) begin
      chk(bus_wdata == mq[0][31:0], "R5", "bus_wdata", bus_wdata, mq[0][31:0]);
      chk(32'(bus_size) == sz(ht), "R2", "bus_size", 32'(bus_size), 32'(sz(ht)));
      chk(bus_seq == (ht == 3'd3), "R2", "bus_seq", 32'(bus_seq), 32'(ht == 3'd3));
    end
    chk(drain_done == (drain_req && mq.size() == 0 && !m_req), "R10", "drain_done",
        32'(drain_done), 32'(drain_req && mq.size() == 0 && !m_req));
    rise = bus_req && !prev_req;
    if (rise && !bus_seq)
      chk((cyc % RATIO) == 0, "R8", "request phase", 32'(cyc % RATIO), 0);
    if (rise && main_pend) begin
      chk(cyc >= main_ack_cyc + MBC * RATIO + 1, "R9", "main hold cycle",
          32'(cyc), 32'(main_ack_cyc + MBC * RATIO + 1));
      main_pend = 0;
    end
    if (rise && push_pend) begin
      chk(cyc >= push_cyc + 2, "R7", "first request cycle", 32'(cyc), 32'(push_cyc + 2));
      push_pend = 0;
    end
    if (ack_cyc == cyc - 1)
      chk(!bus_req, "R11", "req after ack", 32'(bus_req), 0);
    prev_req = bus_req;
  endtask

  always @(posedge clk) begin : mdl
    bit hv, iss, dn, ld, rdy, was_empty;
    logic [2:0]  ht;
    logic [31:0] hvl;
    if (!rst_n) begin
      mq.delete(); m_req = 0; m_cur = 0; m_busy = 0; cyc = 0; last_acc = 0;
      main_pend = 0; push_pend = 0; prev_req = 0; ack_cyc = -10;
    end else begin
      hv  = mq.size() > 0;
      ht  = hv ? mq[0][34:32] : 3'd0;
      hvl = hv ? mq[0][31:0] : 32'd0;
      was_empty = !hv;
      rdy = (mq.size() < DEPTH) && !drain_req;
      dn  = m_req && bus_ack;
      ld  = !m_req && hv && ht[2];
      iss = !m_req && hv && !ht[2] && m_busy == 0 &&
            (ht == 3'd3 || ((cyc + 1) % RATIO) == 0);
      if (dn) begin
        ack_cyc = cyc;
        if (m_cur[31:24] == 8'h02) begin main_pend = 1; main_ack_cyc = cyc; end
      end
      if (dn && m_cur[31:24] == 8'h02) m_busy = MBC * RATIO - 1;
      else if (m_busy > 0) m_busy--;
      if (ld) m_cur = hvl;
      else if (dn) m_cur = m_cur + (32'd1 << sz(ht));
      if (iss) m_req = 1;
      else if (dn) m_req = 0;
      if (dn || ld) void'(mq.pop_front());
      last_acc = push_valid && rdy;
      if (last_acc) begin
        if (was_empty && !push_tag[2]) begin push_pend = 1; push_cyc = cyc; end
        mq.push_back({push_tag, push_val});
      end
      cyc++;
      #1;
      compare();
    end
  end

  // bus responder
  bit ack_en = 1;
  int ack_dly = 0, wcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 0; wcnt = 0;
    end else begin
      bus_ack = 0;
      if (bus_req && ack_en) begin
        if (wcnt >= ack_dly) begin bus_ack = 1; wcnt = 0; end
        else wcnt++;
      end
    end
  end

  task automatic push(input logic [2:0] t, input logic [31:0] v);
    push_valid = 1; push_tag = t; push_val = v;
    do begin @(posedge clk); #2; end while (!last_acc);
    push_valid = 0;
  endtask

  task automatic idle_wait();
    int n = 0;
    do begin @(posedge clk); #2; n++; end while ((mq.size() != 0 || m_req) && n < 2000);
    repeat (3) begin @(posedge clk); #2; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      summary();
    end
  end

  logic [15:0] lf = 16'hACE1;

  initial begin
    rst_n = 0; push_valid = 0; push_tag = 0; push_val = 0; drain_req = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(push_ready == 1, "R1", "push_ready in reset", 32'(push_ready), 1);
    chk(bus_req == 0, "R1", "bus_req in reset", 32'(bus_req), 0);
    chk(drain_done == 0, "R1", "drain_done in reset", 32'(drain_done), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;

    // address entry alone, then mixed sizes outside main RAM
    push(3'd4, 32'h0300_0010);
    repeat (3) begin @(posedge clk); #2; end
    chk(!bus_req && bus_addr == 32'h0300_0010, "R3", "address entry only",
        bus_addr, 32'h0300_0010);
    push(3'd0, 32'h0000_00AA);
    push(3'd1, 32'h0000_BBBB);
    push(3'd2, 32'h1122_3344);
    push(3'd3, 32'h5566_7788);
    push(3'd3, 32'h99AA_BBCC);
    idle_wait();
    chk(bus_addr == 32'h0300_0010 + 1 + 2 + 4 + 4 + 4, "R4", "address after run",
        bus_addr, 32'h0300_0010 + 15);

    // main RAM region with slow acks
    ack_dly = 1;
    push(3'd4, 32'h0200_0100);
    push(3'd2, 32'hDEAD_BEEF);
    push(3'd3, 32'h0BAD_F00D);
    push(3'd0, 32'h0000_0011);
    push(3'd4, 32'h0300_0200);
    push(3'd2, 32'h1234_5678);
    idle_wait();

    // fill to capacity with the bus stalled
    ack_en = 0; ack_dly = 0;
    push(3'd4, 32'h0400_0000);
    for (int i = 0; i < DEPTH; i++) push(3'd3, 32'h100 + 32'(i));
    fork
      begin
        repeat (10) begin @(posedge clk); end
        #3;
        chk(!push_ready, "R6", "ready while full", 32'(push_ready), 0);
        ack_en = 1;
      end
    join_none
    push(3'd2, 32'hFFFF_0001);
    idle_wait();

    // flush with a push held off during it
    ack_dly = 2;
    push(3'd4, 32'h0200_0400);
    push(3'd1, 32'h0000_4444);
    push(3'd2, 32'h5555_5555);
    push(3'd3, 32'h6666_6666);
    drain_req = 1; push_valid = 1; push_tag = 3'd2; push_val = 32'h7777_7777;
    begin
      int n = 0;
      do begin @(posedge clk); #2; n++; end while (!drain_done && n < 500);
    end
    chk(drain_done && mq.size() == 0 && !bus_req, "R10", "flush finished",
        32'(drain_done), 1);
    push_valid = 0; drain_req = 0;
    @(posedge clk); #2;

    // pseudo-random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0] t;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      t = (lf[2:0] > 3'd5) ? 3'd3 : lf[2:0];
      ack_dly = int'(lf[14:13]);
      if (t[2])
        push(t, (lf[3] ? 32'h0200_0000 : 32'h0300_0000) | {22'd0, lf[11:4], 2'b00});
      else
        push(t, {lf, lf ^ 16'h5A5A});
      if (lf[15]) begin @(posedge clk); #2; end
    end
    idle_wait();
    summary();
  end
endmodule